// File: doc/BRIEF.md
# Dual-Clock Byte-to-Halfword FIFO

This block moves a byte stream from one clock domain into a separate, unrelated clock domain. On the read side the stream comes out as 16-bit words. A producer pushes one byte per write-clock cycle. A consumer pulls one word per read-clock cycle, and the word is built from two consecutive bytes. The storage holds 256 bytes, which is 128 words.

Each side keeps its own binary pointer and publishes a Gray-coded copy of it. The other domain samples that copy through a two-flop synchronizer. On the write side, the synchronized read pointer, which counts words, is scaled to bytes. That scaled value gives the full flag and a byte occupancy count. On the read side, the synchronized write pointer, which counts bytes, is reduced to whole words. That reduced value gives the empty flag, so a byte without its partner never becomes visible. One active-low asynchronous reset clears both domains.

Top module: `async_fifo_w2`

## Requirements
- R1: The byte written first of each pair occupies bits 15:8 of the read word and the second occupies bits 7:0; writing 0x00 then 0x01 reads back as 0x0001.
- R2: Read data is registered: it changes on the read-clock edge that accepts a read (rd_en_i high while empty_o low) and holds its value on every other edge.
- R3: A write offered while full_o is high is dropped: the write pointer does not advance and the byte never reaches the read side.
- R4: A read requested while empty_o is high is dropped: the read pointer does not advance and rd_data_o does not change.
- R5: empty_o stays high while fewer than two unread bytes are held; a single odd byte does not make a word readable.
- R6: wr_count_o reports the number of unread bytes as seen from the write domain. full_o rises once 256 bytes are held, and wr_count_o then reads 255 (all ones). After the read side drains, both return to 0 within a few write cycles.
- R7: While rst_ni is low, both pointers clear, empty_o is 1, full_o is 0, wr_count_o is 0 and rd_data_o is 0x0000.
- R8: With unrelated clocks and irregular enables, every accepted pair of bytes is read exactly once, in write order, with none lost or repeated.
- R9: Each Gray-coded pointer sent across domains changes in at most one bit per clock of its own domain, and each binary pointer advances by exactly one on an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-domain clock |
| rd_clk_i | input | 1 | Read-domain clock, asynchronous to wr_clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Write request for one byte |
| wr_data_i | input | 8 | Byte to store |
| full_o | output | 1 | Storage holds 256 bytes (write domain) |
| wr_count_o | output | 8 | Unread bytes, saturating at 255 when full |
| rd_en_i | input | 1 | Read request for one word |
| rd_data_o | output | 16 | Registered read word, first byte in upper half |
| empty_o | output | 1 | No complete word is available (read domain) |

## Verification
The bench writes a single byte and holds it, while repeatedly asking for reads. A design that counts bytes instead of whole words in its empty logic would hand out a half-filled word, and a design that lets the read pointer move while empty would shift every later word by one slot. It then fills the storage to the top and keeps offering a marker byte. A full comparison that ignores the 2:1 pointer scaling would either stop at 128 bytes or overwrite unread data, and the marker would then turn up in the drained stream. A long run with both sides active and random gaps exposes any wrong byte order or a pointer that crosses without Gray coding as a word mismatch. A reset in the middle of traffic must return the flags, the count and the read register to their idle values.

// File: rtl/fifo_w2_pkg.sv
package fifo_w2_pkg;

  localparam int unsigned LANES = 2;

  // lane 0 takes the even (earlier) byte and lands in the upper half
  typedef enum logic {
    LANE_HI = 1'b0,
    LANE_LO = 1'b1
  } lane_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/fifo_w2_sync.sv
module fifo_w2_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/fifo_w2_mem.sv
module fifo_w2_mem
  import fifo_w2_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORDS  = 128
) (
  input  logic                     wr_clk_i,
  input  logic                     wr_en_i,
  input  lane_e                    wr_lane_i,
  input  logic [$clog2(WORDS)-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     rd_clk_i,
  input  logic                     rst_ni,
  input  logic                     rd_en_i,
  input  logic [$clog2(WORDS)-1:0] rd_addr_i,
  output logic [LANES*DATA_W-1:0]  rd_data_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] out_q;

    always_ff @(posedge wr_clk_i) begin
      if (wr_en_i && (wr_lane_i == lane_e'(g))) mem_q[wr_addr_i] <= wr_data_i;
    end

    always_ff @(posedge rd_clk_i or negedge rst_ni) begin
      if (!rst_ni)      out_q <= '0;
      else if (rd_en_i) out_q <= mem_q[rd_addr_i];
    end

    assign rd_data_o[(LANES-1-g)*DATA_W +: DATA_W] = out_q;
  end

endmodule

// File: rtl/fifo_w2_wr.sv
module fifo_w2_wr
  import fifo_w2_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] rd_gray_i,
  output logic          ok_o,
  output logic [AW:0]   ptr_o,
  output logic [AW:0]   gray_o,
  output logic          full_o,
  output logic [AW-1:0] count_o
);

  localparam int unsigned PW  = AW + 1;
  localparam int unsigned RPW = AW;

  logic [PW-1:0]  bin_q, bin_nxt, gray_q, occ;
  logic [RPW-1:0] rd_words;
  logic [PW-1:0]  rd_bytes;
  logic           full;

  // word pointer -> byte pointer
  assign rd_words = RPW'(gray2bin(32'(rd_gray_i)));
  assign rd_bytes = {rd_words, 1'b0};
  assign occ      = bin_q - rd_bytes;
  assign full     = occ[PW-1];
  assign ok_o     = en_i & ~full;
  assign bin_nxt  = bin_q + PW'(ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= PW'(bin2gray(32'(bin_nxt)));
    end
  end

  assign ptr_o   = bin_q;
  assign gray_o  = gray_q;
  assign full_o  = full;
  assign count_o = full ? '1 : occ[AW-1:0];

endmodule

// File: rtl/fifo_w2_rd.sv
module fifo_w2_rd
  import fifo_w2_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW:0]   wr_gray_i,
  output logic          ok_o,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] gray_o,
  output logic          empty_o
);

  localparam int unsigned PW  = AW + 1;
  localparam int unsigned RPW = AW;

  logic [PW-1:0]  wr_bytes;
  logic [RPW-1:0] wr_words, bin_q, bin_nxt, gray_q;
  logic           empty;

  // byte pointer -> whole words only; an odd byte stays hidden
  assign wr_bytes = PW'(gray2bin(32'(wr_gray_i)));
  assign wr_words = RPW'(wr_bytes >> 1);
  assign empty    = (wr_words == bin_q);
  assign ok_o     = en_i & ~empty;
  assign bin_nxt  = bin_q + RPW'(ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= RPW'(bin2gray(32'(bin_nxt)));
    end
  end

  assign ptr_o   = bin_q;
  assign gray_o  = gray_q;
  assign empty_o = empty;

endmodule

// File: rtl/async_fifo_w2.sv
module async_fifo_w2
  import fifo_w2_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BYTE_DEPTH = 256
) (
  input  logic                          wr_clk_i,
  input  logic                          rd_clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic                          full_o,
  output logic [$clog2(BYTE_DEPTH)-1:0] wr_count_o,
  input  logic                          rd_en_i,
  output logic [2*DATA_W-1:0]           rd_data_o,
  output logic                          empty_o
);

  localparam int unsigned AW    = $clog2(BYTE_DEPTH);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned RPW   = AW;
  localparam int unsigned WORDS = BYTE_DEPTH / LANES;
  localparam int unsigned WAW   = $clog2(WORDS);

  logic           wr_ok, rd_ok;
  logic [PW-1:0]  wr_ptr, wr_gray, wr_gray_s;
  logic [RPW-1:0] rd_ptr, rd_gray, rd_gray_s;

  fifo_w2_wr #(.AW(AW)) i_wr (
    .clk_i     (wr_clk_i),
    .rst_ni    (rst_ni),
    .en_i      (wr_en_i),
    .rd_gray_i (rd_gray_s),
    .ok_o      (wr_ok),
    .ptr_o     (wr_ptr),
    .gray_o    (wr_gray),
    .full_o    (full_o),
    .count_o   (wr_count_o)
  );

  fifo_w2_rd #(.AW(AW)) i_rd (
    .clk_i     (rd_clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rd_en_i),
    .wr_gray_i (wr_gray_s),
    .ok_o      (rd_ok),
    .ptr_o     (rd_ptr),
    .gray_o    (rd_gray),
    .empty_o   (empty_o)
  );

  fifo_w2_sync #(.WIDTH(PW)) i_sync_w2r (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    (wr_gray),
    .q_o    (wr_gray_s)
  );

  fifo_w2_sync #(.WIDTH(RPW)) i_sync_r2w (
    .clk_i  (wr_clk_i),
    .rst_ni (rst_ni),
    .d_i    (rd_gray),
    .q_o    (rd_gray_s)
  );

  fifo_w2_mem #(.DATA_W(DATA_W), .WORDS(WORDS)) i_mem (
    .wr_clk_i  (wr_clk_i),
    .wr_en_i   (wr_ok),
    .wr_lane_i (lane_e'(wr_ptr[0])),
    .wr_addr_i (wr_ptr[AW-1:1]),
    .wr_data_i (wr_data_i),
    .rd_clk_i  (rd_clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_ok),
    .rd_addr_i (rd_ptr[WAW-1:0]),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/async_fifo_w2_chk.sv
module async_fifo_w2_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BYTE_DEPTH = 256
) (
  input logic                          wr_clk_i,
  input logic                          rd_clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic                          rd_en_i,
  input logic                          full_o,
  input logic                          empty_o,
  input logic [2*DATA_W-1:0]           rd_data_o,
  input logic [$clog2(BYTE_DEPTH):0]   wr_ptr,
  input logic [$clog2(BYTE_DEPTH)-1:0] rd_ptr,
  input logic [$clog2(BYTE_DEPTH):0]   wr_gray,
  input logic [$clog2(BYTE_DEPTH)-1:0] rd_gray
);

  localparam int unsigned PW  = $clog2(BYTE_DEPTH) + 1;
  localparam int unsigned RPW = $clog2(BYTE_DEPTH);

  AST_WR_BLOCKED_FULL: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    full_o |=> wr_ptr == $past(wr_ptr)); // R3

  AST_RD_BLOCKED_EMPTY: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    empty_o |=> rd_ptr == $past(rd_ptr)); // R4

  AST_RDATA_HOLD: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !(rd_en_i && !empty_o) |=> $stable(rd_data_o)); // R2

  AST_WR_ADVANCE: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_en_i && !full_o) |=> wr_ptr == $past(wr_ptr) + PW'(1)); // R9

  AST_RD_ADVANCE: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_o) |=> rd_ptr == $past(rd_ptr) + RPW'(1)); // R9

  AST_WR_GRAY_ONE_BIT: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $onehot0(wr_gray ^ $past(wr_gray))); // R9

  AST_RD_GRAY_ONE_BIT: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $onehot0(rd_gray ^ $past(rd_gray))); // R9

endmodule

bind async_fifo_w2 async_fifo_w2_chk #(.DATA_W(DATA_W), .BYTE_DEPTH(BYTE_DEPTH)) i_chk (
  .wr_clk_i  (wr_clk_i),
  .rd_clk_i  (rd_clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .rd_data_o (rd_data_o),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .wr_gray   (wr_gray),
  .rd_gray   (rd_gray)
);

// File: tb/test_async_fifo_w2.sv
`timescale 1ns/100ps
module test_async_fifo_w2;

  logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        full, empty;
  logic [7:0]  wr_count;
  logic [15:0] rd_data;

  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [15:0] exp_q[$];
  logic [7:0]  hi_byte = 8'h00;
  bit          have_hi = 1'b0;
  logic [7:0]  nxt = 8'h00;

  always #5 wr_clk = ~wr_clk;    // 100 MHz
  always #8.5 rd_clk = ~rd_clk;  // unrelated read clock

  async_fifo_w2 i_async_fifo_w2 (
    .wr_clk_i   (wr_clk),
    .rd_clk_i   (rd_clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .full_o     (full),
    .wr_count_o (wr_count),
    .rd_en_i    (rd_en),
    .rd_data_o  (rd_data),
    .empty_o    (empty)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: caller stands on a falling wr_clk edge
  task automatic write_byte(input logic [7:0] b);
    while (full) @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = b;
    @(negedge wr_clk);
    wr_en = 1'b0;
    if (!have_hi) begin
      hi_byte = b;
      have_hi = 1'b1;
    end else begin
      exp_q.push_back({hi_byte, b});
      have_hi = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard and compares one cycle after acceptance
  task automatic read_word(input string req);
    logic [15:0] e;
    @(negedge rd_clk);
    while (empty) @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    if (exp_q.size() == 0) begin
      check(1'b0, req, "read with nothing expected", 32'(rd_data), 32'hffff_ffff);
    end else begin
      e = exp_q.pop_front();
      check(rd_data == e, req, "read word", 32'(rd_data), 32'(e));
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    // R7 reset state
    check(empty == 1'b1, "R7", "empty in reset", 32'(empty), 1);
    check(full == 1'b0, "R7", "full in reset", 32'(full), 0);
    check(wr_count == 8'd0, "R7", "count in reset", 32'(wr_count), 0);
    check(rd_data == 16'h0, "R7", "rd_data in reset", 32'(rd_data), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge wr_clk);

    // R5 single odd byte stays invisible
    write_byte(nxt); nxt++;
    @(negedge wr_clk);
    check(wr_count == 8'd1, "R6", "count after one byte", 32'(wr_count), 1);
    repeat (8) @(negedge rd_clk);
    check(empty == 1'b1, "R5", "empty with odd byte", 32'(empty), 1);

    // R4 reads while empty are dropped
    rd_en = 1'b1;
    repeat (4) @(negedge rd_clk);
    rd_en = 1'b0;
    check(rd_data == 16'h0, "R4", "rd_data after blocked reads", 32'(rd_data), 0);
    check(empty == 1'b1, "R4", "still empty", 32'(empty), 1);

    // R1 byte order
    @(negedge wr_clk);
    write_byte(nxt); nxt++;
    read_word("R1");
    check(rd_data == 16'h0001, "R1", "first pair", 32'(rd_data), 32'h0001);

    // R2 output holds without an accepted read
    repeat (4) @(negedge rd_clk);
    check(rd_data == 16'h0001, "R2", "hold while idle", 32'(rd_data), 32'h0001);

    // R6 fill to the top
    @(negedge wr_clk);
    for (int i = 0; i < 256; i++) begin
      write_byte(nxt); nxt++;
    end
    @(negedge wr_clk);
    check(full == 1'b1, "R6", "full after 256 bytes", 32'(full), 1);
    check(wr_count == 8'hff, "R6", "count saturates", 32'(wr_count), 32'hff);

    // R3 writes while full are dropped
    for (int k = 0; k < 5; k++) begin
      check(full == 1'b1, "R3", "full held", 32'(full), 1);
      wr_en   = 1'b1;
      wr_data = 8'hEE;
      @(negedge wr_clk);
      wr_en = 1'b0;
    end
    check(wr_count == 8'hff, "R3", "count after blocked writes", 32'(wr_count), 32'hff);

    // drain; a stored marker byte would show up as a mismatch or leftover word
    for (int i = 0; i < 128; i++) read_word("R3");
    repeat (8) @(negedge wr_clk);
    check(full == 1'b0, "R6", "full cleared after drain", 32'(full), 0);
    check(wr_count == 8'd0, "R6", "count zero after drain", 32'(wr_count), 0);
    check(empty == 1'b1, "R3", "empty after drain", 32'(empty), 1);

    // R8 concurrent stream with irregular gaps
    @(negedge wr_clk);
    fork
      begin
        logic [7:0] lw;
        lw = 8'hA5;
        for (int i = 0; i < 600; i++) begin
          write_byte(nxt); nxt++;
          lw = {lw[6:0], lw[7] ^ lw[5] ^ lw[4] ^ lw[3]};
          if (lw[0]) @(negedge wr_clk);
        end
      end
      begin
        logic [7:0] lr;
        lr = 8'h3C;
        for (int j = 0; j < 300; j++) begin
          read_word("R8");
          lr = {lr[6:0], lr[7] ^ lr[5] ^ lr[4] ^ lr[3]};
          if (lr[1]) repeat (2) @(negedge rd_clk);
        end
      end
    join
    check(exp_q.size() == 0, "R8", "scoreboard drained", 32'(exp_q.size()), 0);
    repeat (4) @(negedge rd_clk);
    check(empty == 1'b1, "R8", "empty after stream", 32'(empty), 1);

    // R7 reset with data in flight
    @(negedge wr_clk);
    for (int i = 0; i < 5; i++) begin
      write_byte(nxt); nxt++;
    end
    read_word("R8");
    repeat (3) @(negedge wr_clk);
    rst_ni = 1'b0;
    #2;
    check(empty == 1'b1, "R7", "empty on mid-run reset", 32'(empty), 1);
    check(full == 1'b0, "R7", "full on mid-run reset", 32'(full), 0);
    check(wr_count == 8'd0, "R7", "count on mid-run reset", 32'(wr_count), 0);
    check(rd_data == 16'h0, "R7", "rd_data on mid-run reset", 32'(rd_data), 0);
    exp_q.delete();
    have_hi = 1'b0;
    repeat (3) @(negedge wr_clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge wr_clk);
    write_byte(8'h5A);
    write_byte(8'hC3);
    read_word("R7");
    finish_run();
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule